// File: doc/BRIEF.md
# GPIO Port Register Block

This block controls one general-purpose I/O port of eight pins. Software reaches it through a small register bus: a two-bit offset, a write strobe with a byte of write data, and a read-data byte that always shows the register at the current offset. Four registers sit at consecutive offsets. They hold the output level, the pin direction and the pull-up request, and a fourth offset returns the synchronized pad levels. Writing ones to that fourth offset inverts the matching output bits. A separate single-bit path takes a bit index with a set or clear strobe. It changes exactly one bit of one register, so code that owns one pin cannot disturb a neighbour.

On the pad side the block drives an output enable, an output level and a pull-up enable for each pin. A peripheral can take over any pin through a per-pin override that supplies its own output enable and output level. Pins that are not overridden keep their register-driven behaviour.

Top module: `gpio_port_regs`

## Requirements
- R1: Synchronous reset clears the output, direction and pull-up registers to 0x00, so pad_oe, pad_out and pad_pu are all 0x00.
- R2: Offset 0 is the output register, offset 1 the direction register and offset 2 the pull-up register. A byte write with bus_wr stores bus_wdata at the selected offset, and a read at that offset returns the stored byte.
- R3: A byte write to offset 3 inverts each output-register bit whose write-data bit is 1. Bits written as 0 and the other registers do not change.
- R4: Reading offset 3 returns the pad inputs through a two-stage synchronizer. A level applied before a clock edge is not visible after one edge and is visible after the second.
- R5: With bus_bset high (and bus_wr, bus_bclr low), the bit selected by bus_bit (0 to 7) is set to 1 in the register at bus_addr 0 to 2. All other bits of all registers keep their values.
- R6: With bus_bclr high (and bus_wr, bus_bset low), the selected bit is cleared to 0 in the register at bus_addr 0 to 2. All other bits keep their values.
- R7: A set strobe at offset 3 inverts the selected output bit. A clear strobe at offset 3 changes nothing.
- R8: bus_wr has priority over the bit strobes. If bus_bset and bus_bclr are high together without bus_wr, no register changes.
- R9: Without override, pad_oe equals the direction register and pad_out equals the output register.
- R10: pad_pu[i] is 1 only when pull-up bit i is 1, direction bit i is 0 and alt_en[i] is 0. Each pin's pull-up is independent of the other pins.
- R11: With alt_en[i] high, pad_oe[i] follows alt_oe[i] and pad_out[i] follows alt_out[i]. Every other pin keeps its register-driven values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bset | input | 1 | Single-bit set strobe |
| bus_bclr | input | 1 | Single-bit clear strobe |
| bus_bit | input | 3 | Bit index for set/clear |
| bus_rdata | output | 8 | Read data at bus_addr |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin pull-up enable |
| alt_en | input | 8 | Per-pin peripheral override |
| alt_oe | input | 8 | Override output enable |
| alt_out | input | 8 | Override output level |

## Verification
The hardest case to reach is a pull-up that is requested but masked. A pin must hold pull-up 1 and direction 0 and then be overridden by a peripheral, while its neighbours keep their own pull-ups. The stimulus first builds distinct direction and pull-up patterns through byte writes and single-bit operations. It then overrides only pin 7 and checks that pin's pull-up goes off while the other pins' enables and levels stay as before. Synchronizer latency is probed by reading offset 3 after one edge and again after the second.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PINS   = 8;
    localparam int BIT_W  = $clog2(PINS);
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        SEL_OUT  = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_PINS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PINS-1:0] outv;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] pull;
    } port_cfg_t;

    function automatic logic [PINS-1:0] bit_mask(input logic [BIT_W-1:0] idx);
        logic [PINS-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic [PINS-1:0]   wdata,
    input  logic              bset,
    input  logic              bclr,
    input  logic [BIT_W-1:0]  bidx,
    input  logic [PINS-1:0]   pins_sync,
    output port_cfg_t         cfg,
    output logic [PINS-1:0]   rdata
);
    reg_sel_e        sel;
    logic [PINS-1:0] mask;
    logic            do_set, do_clr;
    port_cfg_t       cfg_d;

    assign sel    = reg_sel_e'(addr);
    assign mask   = bit_mask(bidx);
    assign do_set = !wr && bset && !bclr;
    assign do_clr = !wr && bclr && !bset;

    always_comb begin
        cfg_d = cfg;
        if (wr) begin
            unique case (sel)
                SEL_OUT:  cfg_d.outv = wdata;
                SEL_DIR:  cfg_d.dir  = wdata;
                SEL_PULL: cfg_d.pull = wdata;
                SEL_PINS: cfg_d.outv = cfg.outv ^ wdata;
            endcase
        end else if (do_set) begin
            unique case (sel)
                SEL_OUT:  cfg_d.outv = cfg.outv | mask;
                SEL_DIR:  cfg_d.dir  = cfg.dir  | mask;
                SEL_PULL: cfg_d.pull = cfg.pull | mask;
                SEL_PINS: cfg_d.outv = cfg.outv ^ mask;
            endcase
        end else if (do_clr) begin
            unique case (sel)
                SEL_OUT:  cfg_d.outv = cfg.outv & ~mask;
                SEL_DIR:  cfg_d.dir  = cfg.dir  & ~mask;
                SEL_PULL: cfg_d.pull = cfg.pull & ~mask;
                SEL_PINS: cfg_d = cfg;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= '0;
        else     cfg <= cfg_d;
    end

    always_comb begin
        unique case (sel)
            SEL_OUT:  rdata = cfg.outv;
            SEL_DIR:  rdata = cfg.dir;
            SEL_PULL: rdata = cfg.pull;
            SEL_PINS: rdata = pins_sync;
        endcase
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pkg::*;
(
    input  port_cfg_t        cfg,
    input  logic [PINS-1:0]  alt_en,
    input  logic [PINS-1:0]  alt_oe,
    input  logic [PINS-1:0]  alt_out,
    output logic [PINS-1:0]  pad_oe,
    output logic [PINS-1:0]  pad_out,
    output logic [PINS-1:0]  pad_pu
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_comb begin
            if (alt_en[i]) begin
                pad_oe[i]  = alt_oe[i];
                pad_out[i] = alt_out[i];
                pad_pu[i]  = 1'b0;
            end else begin
                pad_oe[i]  = cfg.dir[i];
                pad_out[i] = cfg.outv[i];
                pad_pu[i]  = cfg.pull[i] & ~cfg.dir[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_bset,
    input  logic        bus_bclr,
    input  logic [2:0]  bus_bit,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  pad_in,
    output logic [7:0]  pad_oe,
    output logic [7:0]  pad_out,
    output logic [7:0]  pad_pu,
    input  logic [7:0]  alt_en,
    input  logic [7:0]  alt_oe,
    input  logic [7:0]  alt_out
);
    port_cfg_t       cfg;
    logic [PINS-1:0] pins_sync;
    logic [PINS-1:0] out_q, dir_q, pull_q;

    assign out_q  = cfg.outv;
    assign dir_q  = cfg.dir;
    assign pull_q = cfg.pull;

    gpio_sync #(.W(PINS), .STAGES(SYNC_N)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    gpio_regfile i_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .bset      (bus_bset),
        .bclr      (bus_bclr),
        .bidx      (bus_bit),
        .pins_sync (pins_sync),
        .cfg       (cfg),
        .rdata     (bus_rdata)
    );

    gpio_pad_mux i_mux (
        .cfg     (cfg),
        .alt_en  (alt_en),
        .alt_oe  (alt_oe),
        .alt_out (alt_out),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_pu  (pad_pu)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       bus_bset,
    input logic       bus_bclr,
    input logic [2:0] bus_bit,
    input logic [7:0] pad_oe,
    input logic [7:0] pad_out,
    input logic [7:0] pad_pu,
    input logic [7:0] alt_en,
    input logic [7:0] alt_oe,
    input logic [7:0] alt_out,
    input logic [7:0] out_q,
    input logic [7:0] dir_q,
    input logic [7:0] pull_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (out_q == 8'h00 && dir_q == 8'h00 && pull_q == 8'h00));

    // R3
    pin_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=>
            (out_q == ($past(out_q) ^ $past(bus_wdata)) && $stable(dir_q) && $stable(pull_q)));

    // R5
    dir_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && bus_bset && !bus_bclr && bus_addr == 2'd1) |=>
            ($countones(dir_q ^ $past(dir_q)) <= 1 && $stable(out_q) && $stable(pull_q)));

    // R6
    pull_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && bus_bclr && !bus_bset && bus_addr == 2'd2) |=>
            ((pull_q & ~$past(pull_q)) == 8'h00 && $stable(out_q) && $stable(dir_q)));

    // R8
    both_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && bus_bset && bus_bclr) |=>
            ($stable(out_q) && $stable(dir_q) && $stable(pull_q)));

    // R10
    pull_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu & (dir_q | alt_en)) == 8'h00) && ((pad_pu & ~pull_q) == 8'h00));

    // R11
    alt_override_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & alt_en) == (alt_oe & alt_en)) && ((pad_out & alt_en) == (alt_out & alt_en)));

    // R9
    no_override_chk: assert property (@(posedge clk) disable iff (rst)
        (alt_en == 8'h00) |-> (pad_oe == dir_q && pad_out == out_q));
endmodule

bind gpio_port_regs gpio_port_chk i_chk (.*);

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic       bus_bset;
    logic       bus_bclr;
    logic [2:0] bus_bit;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_oe, pad_out, pad_pu;
    logic [7:0] alt_en, alt_oe, alt_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port_regs i_gpio_port_regs (.*);

    // op: 0 write, 1 set, 2 clear, 3 none | addr | data/bit | check addr | expected
    localparam int NV = 13;
    localparam logic [21:0] TBL [NV] = '{
        {2'd0, 2'd0, 8'hA5, 2'd0, 8'hA5},  // R2
        {2'd0, 2'd1, 8'h0F, 2'd1, 8'h0F},  // R2
        {2'd0, 2'd2, 8'hF0, 2'd2, 8'hF0},  // R2
        {2'd0, 2'd3, 8'h03, 2'd0, 8'hA6},  // R3
        {2'd0, 2'd3, 8'h00, 2'd0, 8'hA6},  // R3
        {2'd3, 2'd0, 8'h00, 2'd1, 8'h0F},  // R3 dir untouched
        {2'd1, 2'd1, 8'h06, 2'd1, 8'h4F},  // R5
        {2'd2, 2'd2, 8'h04, 2'd2, 8'hE0},  // R6
        {2'd1, 2'd0, 8'h00, 2'd0, 8'hA7},  // R5
        {2'd2, 2'd0, 8'h07, 2'd0, 8'h27},  // R6
        {2'd1, 2'd3, 8'h01, 2'd0, 8'h25},  // R7
        {2'd2, 2'd3, 8'h01, 2'd0, 8'h25},  // R7
        {2'd3, 2'd0, 8'h00, 2'd1, 8'h4F}   // R5 dir kept
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_wr = 1'b0; bus_bset = 1'b0; bus_bclr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_op(input logic [1:0] op, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = (op == 2'd0);
        bus_bset = (op == 2'd1);
        bus_bclr = (op == 2'd2);
        bus_wdata = d;
        bus_bit  = d[2:0];
        @(negedge clk);
        idle_bus();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; idle_bus(); bus_addr = 2'd0; bus_wdata = 8'h00; bus_bit = 3'd0;
        pad_in = 8'h00; alt_en = 8'h00; alt_oe = 8'h00; alt_out = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        read_chk("R1", 2'd0, 8'h00);
        read_chk("R1", 2'd1, 8'h00);
        read_chk("R1", 2'd2, 8'h00);
        check("R1", pad_oe, 8'h00);
        check("R1", pad_pu, 8'h00);

        for (int k = 0; k < NV; k++) begin
            do_op(TBL[k][21:20], TBL[k][19:18], TBL[k][17:10]);
            read_chk("R2/R3/R5/R6/R7 table", TBL[k][9:8], TBL[k][7:0]);
        end

        // R9 pads without override: dir 4F, out 25, pull E0
        check("R9", pad_oe, 8'h4F);
        check("R9", pad_out, 8'h25);
        // R10 pull masked where direction is output
        check("R10", pad_pu, 8'hA0);

        // R11 override pin 7 only
        @(negedge clk);
        alt_en = 8'h80; alt_oe = 8'h80; alt_out = 8'h80;
        #1;
        check("R11", pad_oe, 8'hCF);
        check("R11", pad_out, 8'hA5);
        check("R10", pad_pu, 8'h20);
        alt_en = 8'h00; alt_oe = 8'h00; alt_out = 8'h00;

        // R8 both strobes: nothing changes
        @(negedge clk);
        bus_addr = 2'd1; bus_bset = 1'b1; bus_bclr = 1'b1; bus_bit = 3'd0;
        @(negedge clk); idle_bus();
        read_chk("R8", 2'd1, 8'h4F);

        // R8 write beats set
        @(negedge clk);
        bus_addr = 2'd2; bus_wr = 1'b1; bus_wdata = 8'h11; bus_bset = 1'b1; bus_bit = 3'd7;
        @(negedge clk); idle_bus();
        read_chk("R8", 2'd2, 8'h11);

        // R4 synchronizer latency
        read_chk("R4", 2'd3, 8'h00);
        pad_in = 8'h3C;
        @(negedge clk);
        read_chk("R4", 2'd3, 8'h00);
        @(negedge clk);
        read_chk("R4", 2'd3, 8'h3C);
        // R4 write to pin offset with zero data leaves registers alone
        do_op(2'd0, 2'd3, 8'h00);
        read_chk("R4", 2'd0, 8'h25);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_chk("R1", 2'd0, 8'h00);
        read_chk("R1", 2'd1, 8'h00);
        read_chk("R1", 2'd2, 8'h00);
        check("R1", pad_out, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule